// File: doc/BRIEF.md
# DMA Burst Splitter for a Cache-Line Slave Port

The block takes one transfer request from a DMA engine: a start address, a byte length and a direction. It turns that request into a series of short, aligned, incrementing bursts on a simplified address/data/response channel. The slave port behind it accepts only 16-byte and 64-byte bursts, and each burst must be aligned to its own size. Splitting is done entirely in hardware, so software never sees the individual bursts.

The block issues one burst at a time. The next address phase waits until the response for the current burst arrives. Write data flows straight from the requester to the port, and the block marks the final beat of each burst. Read data flows straight back to the requester. A request that breaks the size or alignment rules ends at once with an error status, and nothing is issued on the port. An error response from the port stops the sequence and reports the address of the burst that failed. A successful transfer ends with a one-cycle done pulse that carries OKAY status.

Top module: `dma_burst_split`

## Requirements
- R1: After reset the block is idle: `req_ready_o` is 1, and `bus_addr_valid_o`, `bus_wvalid_o` and `done_o` are 0.
- R2: Every burst is either 16 bytes (`bus_big_o`=0, 16/BEAT_BYTES beats) or 64 bytes (`bus_big_o`=1, 64/BEAT_BYTES beats), and its address is a multiple of its own size.
- R3: A 64-byte burst is issued when the current address has its low 6 bits zero and at least 64 bytes remain. In every other case a 16-byte burst is issued.
- R4: The first burst starts at the request address. Each following burst starts at the previous burst address plus the previous burst size. The burst sizes add up to the request length.
- R5: A request whose address bits [3:0] are not zero, whose length bits [3:0] are not zero, or whose length is zero ends with `done_o`=1 and `done_err_o`=1 on the cycle after it is accepted. In that case `err_addr_o` equals the request address and no burst is issued.
- R6: No new address phase starts while a burst is waiting for its response. While the address is stalled, the address and size stay stable.
- R7: On a write, data beats pass from `wr_data_i` to `bus_wdata_o` unchanged and in order. `bus_wlast_o` is 1 exactly on the final beat of each burst.
- R8: On a read, every `bus_rdata_i` beat appears on `rd_data_o` in the same cycle, with `rd_valid_o` set.
- R9: An error response (`bus_resp_err_i`=1) on any burst ends the request with `done_o`=1 and `done_err_o`=1 on the next cycle. `err_addr_o` then holds that burst's address, and no further bursts are issued.
- R10: After the response to the last burst is OKAY, `done_o` is 1 with `done_err_o`=0 on the next cycle, for exactly one cycle.
- R11: `req_ready_o` is 0 from the cycle after a legal request is accepted until the request finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken |
| req_addr_i | input | AW | Start byte address |
| req_len_i | input | LW | Length in bytes |
| req_write_i | input | 1 | 1 = write, 0 = read |
| wr_valid_i | input | 1 | Write beat from requester valid |
| wr_ready_o | output | 1 | Write beat accepted |
| wr_data_i | input | DW | Write beat data |
| rd_valid_o | output | 1 | Read beat to requester valid |
| rd_data_o | output | DW | Read beat data |
| done_o | output | 1 | One-cycle completion pulse |
| done_err_o | output | 1 | Completion status, 1 = error |
| err_addr_o | output | AW | Address of failing request or burst |
| bus_addr_valid_o | output | 1 | Burst address valid |
| bus_addr_ready_i | input | 1 | Burst address accepted |
| bus_addr_o | output | AW | Burst start address |
| bus_big_o | output | 1 | 1 = 64-byte burst, 0 = 16-byte burst |
| bus_write_o | output | 1 | Burst direction |
| bus_wvalid_o | output | 1 | Write beat valid |
| bus_wready_i | input | 1 | Write beat accepted |
| bus_wdata_o | output | DW | Write beat data |
| bus_wlast_o | output | 1 | Final beat of burst |
| bus_rvalid_i | input | 1 | Read beat valid |
| bus_rdata_i | input | DW | Read beat data |
| bus_resp_valid_i | input | 1 | Burst response valid |
| bus_resp_err_i | input | 1 | Burst response is an error |

## Verification
A wrong address or remaining-length register shows up at the very next address phase as a burst with the wrong start or size. The scoreboard compares each burst against a list built from the request, so that burst is flagged as soon as it is issued. A wrong beat counter shows up within one burst as a misplaced last-beat marker or as a data beat that the port model never requested. A wrong state after a response shows up within a cycle or two in one of three ways: a second address phase while a response is still pending, a missing or stretched done pulse, or the wrong error address.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int unsigned SMALL_BYTES = 16;
  localparam int unsigned BIG_BYTES   = 64;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_RESP
  } dbs_state_e;
endpackage

// File: rtl/dbs_req_check.sv
module dbs_req_check #(
  parameter int unsigned LW = 16
) (
  input  logic [3:0]    addr_lo_i,
  input  logic [LW-1:0] len_i,
  output logic          legal_o
);
  // start and length must both be whole 16-byte units, and length nonzero
  always_comb begin
    legal_o = (addr_lo_i == 4'h0) && (len_i[3:0] == 4'h0) && (len_i != '0);
  end
endmodule

// File: rtl/dbs_burst_plan.sv
module dbs_burst_plan #(
  parameter int unsigned LW = 16
) (
  input  logic [5:0]    addr_lo_i,
  input  logic [LW-1:0] rem_i,
  output logic          big_o,
  output logic [LW-1:0] size_o,
  output logic          last_o
);
  import dbs_pkg::*;
  localparam logic [LW-1:0] BIG_LEN   = LW'(BIG_BYTES);
  localparam logic [LW-1:0] SMALL_LEN = LW'(SMALL_BYTES);

  always_comb begin
    big_o  = (addr_lo_i == 6'd0) && (rem_i >= BIG_LEN);
    size_o = big_o ? BIG_LEN : SMALL_LEN;
    last_o = (rem_i == size_o);
  end
endmodule

// File: rtl/dbs_beat_cnt.sv
module dbs_beat_cnt #(
  parameter int unsigned BEAT_BYTES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic big_i,
  input  logic step_i,
  output logic last_o
);
  import dbs_pkg::*;
  localparam int unsigned SMALL_BEATS = SMALL_BYTES / BEAT_BYTES;
  localparam int unsigned BIG_BEATS   = BIG_BYTES / BEAT_BYTES;
  localparam int unsigned CW          = $clog2(BIG_BEATS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= big_i ? CW'(BIG_BEATS - 1) : CW'(SMALL_BEATS - 1);
    end else if (step_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last_o = (cnt_q == '0);

  // R7
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !last_o |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dma_burst_split.sv
module dma_burst_split #(
  parameter int unsigned AW         = 32,
  parameter int unsigned LW         = 16,
  parameter int unsigned BEAT_BYTES = 8,
  localparam int unsigned DW        = BEAT_BYTES * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [LW-1:0] req_len_i,
  input  logic          req_write_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  input  logic [DW-1:0] wr_data_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o,
  output logic          done_err_o,
  output logic [AW-1:0] err_addr_o,
  output logic          bus_addr_valid_o,
  input  logic          bus_addr_ready_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_big_o,
  output logic          bus_write_o,
  output logic          bus_wvalid_o,
  input  logic          bus_wready_i,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_wlast_o,
  input  logic          bus_rvalid_i,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_resp_valid_i,
  input  logic          bus_resp_err_i
);
  import dbs_pkg::*;

  dbs_state_e    state_q, state_d;
  logic [AW-1:0] cur_addr_q;
  logic [LW-1:0] rem_q;
  logic          write_q;
  logic          big_q;
  logic          last_q;
  logic [LW-1:0] size_q;
  logic          done_q, done_err_q;
  logic [AW-1:0] err_addr_q;

  logic          legal;
  logic          plan_big, plan_last;
  logic [LW-1:0] plan_size;
  logic          beat_last;
  logic          req_acc, addr_acc, w_acc, resp_acc;

  dbs_req_check #(.LW(LW)) i_req_check (
    .addr_lo_i (req_addr_i[3:0]),
    .len_i     (req_len_i),
    .legal_o   (legal)
  );

  dbs_burst_plan #(.LW(LW)) i_burst_plan (
    .addr_lo_i (cur_addr_q[5:0]),
    .rem_i     (rem_q),
    .big_o     (plan_big),
    .size_o    (plan_size),
    .last_o    (plan_last)
  );

  dbs_beat_cnt #(.BEAT_BYTES(BEAT_BYTES)) i_beat_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (addr_acc),
    .big_i  (plan_big),
    .step_i (w_acc),
    .last_o (beat_last)
  );

  assign req_ready_o      = (state_q == ST_IDLE);
  assign req_acc          = req_valid_i && req_ready_o;
  assign bus_addr_valid_o = (state_q == ST_ADDR);
  assign bus_addr_o       = cur_addr_q;
  assign bus_big_o        = plan_big;
  assign bus_write_o      = write_q;
  assign addr_acc         = bus_addr_valid_o && bus_addr_ready_i;

  // write beats pass straight through while a write burst is in its data phase
  assign bus_wvalid_o = (state_q == ST_DATA) && wr_valid_i;
  assign wr_ready_o   = (state_q == ST_DATA) && bus_wready_i;
  assign bus_wdata_o  = wr_data_i;
  assign bus_wlast_o  = (state_q == ST_DATA) && beat_last;
  assign w_acc        = bus_wvalid_o && bus_wready_i;

  assign rd_valid_o = (state_q == ST_RESP) && !write_q && bus_rvalid_i;
  assign rd_data_o  = bus_rdata_i;

  assign resp_acc = (state_q == ST_RESP) && bus_resp_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_acc && legal) state_d = ST_ADDR;
      ST_ADDR: if (addr_acc) state_d = write_q ? ST_DATA : ST_RESP;
      ST_DATA: if (w_acc && beat_last) state_d = ST_RESP;
      ST_RESP: begin
        if (resp_acc) begin
          state_d = (bus_resp_err_i || last_q) ? ST_IDLE : ST_ADDR;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cur_addr_q <= '0;
      rem_q      <= '0;
      write_q    <= 1'b0;
      big_q      <= 1'b0;
      last_q     <= 1'b0;
      size_q     <= '0;
      done_q     <= 1'b0;
      done_err_q <= 1'b0;
      err_addr_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (req_acc) begin
        cur_addr_q <= req_addr_i;
        rem_q      <= req_len_i;
        write_q    <= req_write_i;
        if (!legal) begin
          done_q     <= 1'b1;
          done_err_q <= 1'b1;
          err_addr_q <= req_addr_i;
        end
      end
      if (addr_acc) begin
        big_q  <= plan_big;
        last_q <= plan_last;
        size_q <= plan_size;
      end
      if (resp_acc) begin
        if (bus_resp_err_i) begin
          done_q     <= 1'b1;
          done_err_q <= 1'b1;
          err_addr_q <= cur_addr_q;
        end else begin
          cur_addr_q <= cur_addr_q + AW'(size_q);
          rem_q      <= rem_q - size_q;
          if (last_q) begin
            done_q     <= 1'b1;
            done_err_q <= 1'b0;
          end
        end
      end
    end
  end

  assign done_o     = done_q;
  assign done_err_o = done_err_q;
  assign err_addr_o = err_addr_q;

  // R2
  burst_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_valid_o |-> (bus_addr_o[3:0] == 4'h0) && (!bus_big_o || bus_addr_o[5:0] == 6'd0));

  // R6
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_valid_o && !bus_addr_ready_i |=> bus_addr_valid_o && $stable(bus_addr_o) && $stable(bus_big_o));

  // R7
  wlast_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_acc && bus_wlast_o |=> !bus_wvalid_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  busy_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_addr_valid_o |-> !req_ready_o);

  // R4
  incr_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_acc && !bus_resp_err_i && !last_q |=> bus_addr_o == $past(bus_addr_o) + AW'($past(size_q)));
endmodule

// File: tb/test_dma_burst_split.sv
module test_dma_burst_split;
  localparam int unsigned AW = 32;
  localparam int unsigned LW = 16;
  localparam int unsigned BB = 8;
  localparam int unsigned DW = BB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          req_write = 1'b0;
  logic          wr_valid = 1'b1;
  logic          wr_ready;
  logic [DW-1:0] wr_data;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          done, done_err;
  logic [AW-1:0] err_addr;
  logic          a_valid, a_ready = 1'b0;
  logic [AW-1:0] a_addr;
  logic          a_big, a_write;
  logic          w_valid, w_ready = 1'b0;
  logic [DW-1:0] w_data;
  logic          w_last;
  logic          r_valid = 1'b0;
  logic [DW-1:0] r_data = '0;
  logic          b_valid = 1'b0, b_err = 1'b0;

  dma_burst_split #(.AW(AW), .LW(LW), .BEAT_BYTES(BB)) i_dma_burst_split (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_len_i(req_len), .req_write_i(req_write),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_data_i(wr_data),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .done_o(done), .done_err_o(done_err), .err_addr_o(err_addr),
    .bus_addr_valid_o(a_valid), .bus_addr_ready_i(a_ready), .bus_addr_o(a_addr),
    .bus_big_o(a_big), .bus_write_o(a_write),
    .bus_wvalid_o(w_valid), .bus_wready_i(w_ready), .bus_wdata_o(w_data), .bus_wlast_o(w_last),
    .bus_rvalid_i(r_valid), .bus_rdata_i(r_data),
    .bus_resp_valid_i(b_valid), .bus_resp_err_i(b_err)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [AW-1:0] addr;
    logic          big;
    logic          write;
  } burst_t;

  burst_t q[$];
  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int inj = -1, bidx = 0;
  int resp_cyc = 0;
  int wexp = 0;
  int wr_cnt = 0;
  int outstanding = 0;
  int gstall = 0;
  bit finished = 0;

  assign wr_data = DW'(wr_cnt);

  initial forever begin
    @(posedge clk);
    cyc <= cyc + 1;
    if (wr_valid && wr_ready) wr_cnt <= wr_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // port model: accepts bursts, compares them with the scoreboard, moves data, responds
  initial forever begin
    @(negedge clk);
    if (rst_n && a_valid) begin
      burst_t e;
      int nb;
      repeat (gstall % 3) @(negedge clk);
      gstall++;
      if (q.size() == 0) begin
        check(0, "R5/R9", "unexpected burst addr", longint'(a_addr), 0);
      end else begin
        e = q.pop_front();
        check(a_addr == e.addr, "R4", "burst addr", longint'(a_addr), longint'(e.addr));
        check(a_big == e.big, "R3", "burst size big", longint'(a_big), longint'(e.big));
        check(a_write == e.write, "R2", "burst dir", longint'(a_write), longint'(e.write));
      end
      nb = a_big ? 64 / BB : 16 / BB;
      a_ready = 1'b1;
      @(negedge clk);
      a_ready = 1'b0;
      outstanding = 1;
      if (a_write) begin
        w_ready = 1'b1;
        for (int b = 0; b < nb; b++) begin
          check(w_valid, "R7", "wvalid", longint'(w_valid), 1);
          check(w_data == DW'(wexp), "R7", "wdata", longint'(w_data), longint'(wexp));
          check(w_last == (b == nb - 1), "R7", "wlast", longint'(w_last), longint'(b == nb - 1));
          wexp++;
          @(negedge clk);
        end
        w_ready = 1'b0;
      end else begin
        for (int b = 0; b < nb; b++) begin
          r_valid = 1'b1;
          r_data  = DW'(64'hA500_0000 + bidx * 16 + b);
          #1;
          check(rd_valid && rd_data == r_data, "R8", "read beat", longint'(rd_data), longint'(r_data));
          @(negedge clk);
        end
        r_valid = 1'b0;
      end
      repeat (gstall % 2) @(negedge clk);
      b_valid  = 1'b1;
      b_err    = (bidx == inj);
      resp_cyc = cyc;
      @(negedge clk);
      outstanding = 0;
      b_valid = 1'b0;
      b_err   = 1'b0;
      bidx++;
    end
  end

  // R6: no second address phase while a response is pending
  initial forever begin
    @(negedge clk);
    #2;
    if (rst_n && outstanding != 0 && a_valid)
      check(0, "R6", "addr while outstanding", 1, 0);
  end

  task automatic run(input logic [AW-1:0] addr, input logic [LW-1:0] len,
                     input bit wr, input int err_at);
    bit legal;
    bit exp_err;
    logic [AW-1:0] exp_eaddr;
    logic [AW-1:0] a;
    int r, k, req_cyc, t;
    legal = (addr[3:0] == 0) && (len[3:0] == 0) && (len != 0);
    exp_err = !legal;
    exp_eaddr = addr;
    if (legal) begin
      a = addr; r = int'(len); k = 0;
      while (r > 0) begin
        burst_t e;
        e.addr = a; e.write = wr;
        e.big = (a[5:0] == 0) && (r >= 64);
        if (k <= err_at || err_at < 0) q.push_back(e);
        if (k == err_at) begin exp_err = 1; exp_eaddr = a; end
        a = a + (e.big ? 64 : 16);
        r = r - (e.big ? 64 : 16);
        k++;
      end
    end
    @(negedge clk);
    inj = err_at; bidx = 0; wexp = 0; wr_cnt = 0;
    req_valid = 1'b1; req_addr = addr; req_len = len; req_write = wr;
    check(req_ready, "R11", "ready when idle", longint'(req_ready), 1);
    req_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    if (legal) check(!req_ready, "R11", "ready while busy", longint'(req_ready), 0);
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    check(done, exp_err ? "R9" : "R10", "done seen", longint'(done), 1);
    if (!legal)
      check(cyc == req_cyc + 1, "R5", "done cycle", longint'(cyc), longint'(req_cyc + 1));
    else
      check(cyc == resp_cyc + 1, exp_err ? "R9" : "R10", "done cycle",
            longint'(cyc), longint'(resp_cyc + 1));
    check(done_err == exp_err, exp_err ? "R5/R9" : "R10", "status",
          longint'(done_err), longint'(exp_err));
    if (exp_err)
      check(err_addr == exp_eaddr, legal ? "R9" : "R5", "err addr",
            longint'(err_addr), longint'(exp_eaddr));
    @(negedge clk);
    check(!done, "R10", "done one cycle", longint'(done), 0);
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R4", "bursts left", longint'(q.size()), 0);
    check(!a_valid, "R9", "no burst after end", longint'(a_valid), 0);
    q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(req_ready, "R1", "reset ready", longint'(req_ready), 1);
    check(!a_valid && !w_valid && !done, "R1", "reset idle outputs",
          longint'({a_valid, w_valid, done}), 0);
    run(32'h1000, 16'd64,  1'b1, -1);   // R2 one 64-byte write
    run(32'h1010, 16'd112, 1'b1, -1);   // R3 small small small big
    run(32'h2000, 16'd208, 1'b0, -1);   // R8 read, big x3 then small
    run(32'h3030, 16'd32,  1'b0, -1);   // R3 aligned but too short for big
    run(32'h1004, 16'd32,  1'b1, -1);   // R5 misaligned address
    run(32'h1000, 16'd24,  1'b0, -1);   // R5 odd length
    run(32'h1000, 16'd0,   1'b1, -1);   // R5 zero length
    run(32'h4000, 16'd256, 1'b1, 2);    // R9 error on third burst
    run(32'h5010, 16'd48,  1'b0, 0);    // R9 error on first burst
    run(32'h6000, 16'd16,  1'b1, -1);   // R10 recovery after error
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule